// File: doc/BRIEF.md
# Interleave Target Port Selector

This block sits in the downstream routing path of a memory bridge or switch. On each request it takes a host physical address and searches a small set of address-range slots. The slots are searched in ascending order, and the first slot whose window contains the address is the one that claims it. The slot registers live elsewhere; this block receives the base, the size, the interleave settings, a committed flag and a 64-bit list of eight byte-wide port numbers for every slot.

When the claiming slot is committed, the address is cut into granules of 2^(ig+8) bytes. The granule number is reduced modulo the number of interleave ways, and the result indexes the slot's target list to give an 8-bit downstream port number. The division and the modulo are done as a shift and a mask. A separate 4-bit encoded field says how many slots the scan covers.

The result is registered. It appears with a one-cycle valid pulse in the cycle after the request.

Top module: `ilv_port_sel`

## Requirements
- R1: `vld_o` is high in exactly the cycle after each cycle in which `req_i` is high, and low otherwise.
- R2: The scan covers slot i only when i is below the decoded count of `cnt_enc_i`. Encodings 0, 1 and 2 give 1, 2 and 4 slots. Encodings 3 through 12 give 6 to 32 slots, limited to NUM_SLOTS. Encodings 13 to 15 give zero slots, so the lookup never hits.
- R3: A slot's base is {base_hi, base_lo[31:28], 28'h0} and its size is {size_hi, size_lo[31:28], 28'h0`}. Bits [27:0] of the low words have no effect.
- R4: A slot contains the address when base <= addr < base + size. The sum is formed without wraparound, so a window that ends exactly at 2^64 contains the address 2^64-1.
- R5: When several enabled slots contain the address, the lowest-numbered slot decides the result.
- R6: When the lowest containing slot has `committed_i` low, `hit_o` is 0, even if a later committed slot also contains the address.
- R7: The target index is (addr / 2^(ig+8)) mod 2^w, where w is `iw_i` and any `iw_i` value above 3 counts as 3.
- R8: An index k selects `tgt_i[slot][8k+7:8k]`. Indices 0-3 select bytes of the low word and 4-7 select bytes of the high word.
- R9: When no enabled slot contains the address, `hit_o` is 0 and `port_o` is 0.
- R10: In cycles with no request, `hit_o` and `port_o` keep the result of the last request. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request strobe |
| addr_i | input | ADDR_W | Host physical address |
| cnt_enc_i | input | 4 | Encoded count of slots to scan |
| base_lo_i | input | NUM_SLOTS x 32 | Low base word per slot (bits 31:28 used) |
| base_hi_i | input | NUM_SLOTS x 32 | High base word per slot |
| size_lo_i | input | NUM_SLOTS x 32 | Low size word per slot (bits 31:28 used) |
| size_hi_i | input | NUM_SLOTS x 32 | High size word per slot |
| ig_i | input | NUM_SLOTS x 4 | Granule exponent per slot |
| iw_i | input | NUM_SLOTS x 4 | Ways exponent per slot |
| committed_i | input | NUM_SLOTS | Slot committed flag |
| tgt_i | input | NUM_SLOTS x 64 | Eight packed 8-bit port numbers per slot |
| vld_o | output | 1 | Result valid pulse |
| hit_o | output | 1 | Address claimed by a committed slot |
| port_o | output | 8 | Selected downstream port number |

## Verification
The assertions assume that the slot configuration inputs hold steady in the cycle a request is sampled. They also assume that ADDR_W is no wider than 64 bits, so that base plus size fits in 65 bits. The bench changes the configuration only on falling edges while no request is pending, and it uses 64-bit addresses throughout. The slot-0 commitment property relies on the checker computing the slot-0 window from the ports alone. The stimulus therefore places overlapping and uncommitted windows on slot 0 as well as on later slots.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // decoded slot count for the 4-bit capability encoding; 0 when unsupported
  function automatic logic [5:0] slot_count(input logic [3:0] enc);
    logic [5:0] n;
    case (enc)
      4'h0: n = 6'd1;
      4'h1: n = 6'd2;
      4'h2: n = 6'd4;
      4'h3: n = 6'd6;
      4'h4: n = 6'd8;
      4'h5: n = 6'd10;
      4'h6: n = 6'd12;
      4'h7: n = 6'd14;
      4'h8: n = 6'd16;
      4'h9: n = 6'd20;
      4'ha: n = 6'd24;
      4'hb: n = 6'd28;
      4'hc: n = 6'd32;
      default: n = 6'd0;
    endcase
    return n;
  endfunction

  localparam logic [63:0] WIN_MASK = 64'hFFFF_FFFF_F000_0000;

endpackage

// File: rtl/ilv_slot_match.sv
module ilv_slot_match
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       base_lo_i,
  input  logic [31:0]       base_hi_i,
  input  logic [31:0]       size_lo_i,
  input  logic [31:0]       size_hi_i,
  output logic              hit_o
);
  localparam int CMP_W = 65;

  logic [63:0]      base, size;
  logic [CMP_W-1:0] lo_bound, hi_bound, addr_ext;

  assign base     = {base_hi_i, base_lo_i} & WIN_MASK;
  assign size     = {size_hi_i, size_lo_i} & WIN_MASK;
  assign lo_bound = {1'b0, base};
  assign hi_bound = {1'b0, base} + {1'b0, size};  // no wrap at 2^64
  assign addr_ext = CMP_W'(addr_i);
  assign hit_o    = (addr_ext >= lo_bound) && (addr_ext < hi_bound);

endmodule

// File: rtl/ilv_first_pick.sv
module ilv_first_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ilv_port_extract.sv
module ilv_port_extract #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        ig_i,
  input  logic [3:0]        iw_i,
  input  logic [63:0]       tgt_i,
  output logic [7:0]        port_o
);
  logic [4:0] shamt;
  logic [2:0] gran_idx, way_mask, idx;
  logic [1:0] iw_c;

  assign shamt    = {1'b0, ig_i} + 5'd8;
  assign gran_idx = 3'(addr_i >> shamt);
  assign iw_c     = (iw_i > 4'd3) ? 2'd3 : iw_i[1:0];  // list holds 8 entries
  assign way_mask = 3'((4'd1 << iw_c) - 4'd1);
  assign idx      = gran_idx & way_mask;
  assign port_o   = tgt_i[{idx, 3'b000} +: 8];

endmodule

// File: rtl/ilv_port_sel.sv
module ilv_port_sel
  import ilv_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [3:0]                  cnt_enc_i,
  input  logic [NUM_SLOTS-1:0][31:0]  base_lo_i,
  input  logic [NUM_SLOTS-1:0][31:0]  base_hi_i,
  input  logic [NUM_SLOTS-1:0][31:0]  size_lo_i,
  input  logic [NUM_SLOTS-1:0][31:0]  size_hi_i,
  input  logic [NUM_SLOTS-1:0][3:0]   ig_i,
  input  logic [NUM_SLOTS-1:0][3:0]   iw_i,
  input  logic [NUM_SLOTS-1:0]        committed_i,
  input  logic [NUM_SLOTS-1:0][63:0]  tgt_i,
  output logic                        vld_o,
  output logic                        hit_o,
  output logic [7:0]                  port_o
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] in_win, enabled;
  logic [5:0]           scan_n;
  logic                 any_win, hit_d;
  logic [IDX_W-1:0]     sel;
  logic [7:0]           port_d;
  logic                 vld_q, hit_q;
  logic [7:0]           port_q;

  assign scan_n = slot_count(cnt_enc_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    ilv_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .addr_i   (addr_i),
      .base_lo_i(base_lo_i[g]),
      .base_hi_i(base_hi_i[g]),
      .size_lo_i(size_lo_i[g]),
      .size_hi_i(size_hi_i[g]),
      .hit_o    (in_win[g])
    );
    assign enabled[g] = (32'(g) < 32'(scan_n));
  end

  ilv_first_pick #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .cand_i(in_win & enabled),
    .any_o (any_win),
    .idx_o (sel)
  );

  ilv_port_extract #(.ADDR_W(ADDR_W)) u_extract (
    .addr_i(addr_i),
    .ig_i  (ig_i[sel]),
    .iw_i  (iw_i[sel]),
    .tgt_i (tgt_i[sel]),
    .port_o(port_d)
  );

  // first claimant decides; uncommitted claimant blocks later slots
  assign hit_d = any_win & committed_i[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      port_q <= 8'h00;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        hit_q  <= hit_d;
        port_q <= hit_d ? port_d : 8'h00;
      end
    end
  end

  assign vld_o  = vld_q;
  assign hit_o  = hit_q;
  assign port_o = port_q;

endmodule

// File: rtl/ilv_port_sel_chk.sv
module ilv_port_sel_chk
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [3:0]        cnt_enc_i,
  input logic [31:0]       base_lo0_i,
  input logic [31:0]       base_hi0_i,
  input logic [31:0]       size_lo0_i,
  input logic [31:0]       size_hi0_i,
  input logic              committed0_i,
  input logic              vld_o,
  input logic              hit_o,
  input logic [7:0]        port_o
);
  logic [64:0] c_lo, c_hi, c_addr;
  logic        c_in0;

  assign c_lo   = {1'b0, {base_hi0_i, base_lo0_i} & WIN_MASK};
  assign c_hi   = c_lo + {1'b0, {size_hi0_i, size_lo0_i} & WIN_MASK};
  assign c_addr = 65'(addr_i);
  assign c_in0  = (c_addr >= c_lo) && (c_addr < c_hi);

  a_r1_vld_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);

  a_r1_no_spurious_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);

  a_r2_bad_count_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cnt_enc_i > 4'hc) |=> !hit_o);

  a_r6_uncommitted_first_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cnt_enc_i <= 4'hc && c_in0 && !committed0_i) |=> !hit_o);

  a_r9_miss_port_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> port_o == 8'h00);

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(hit_o) && $stable(port_o)));

endmodule

bind ilv_port_sel ilv_port_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .addr_i      (addr_i),
  .cnt_enc_i   (cnt_enc_i),
  .base_lo0_i  (base_lo_i[0]),
  .base_hi0_i  (base_hi_i[0]),
  .size_lo0_i  (size_lo_i[0]),
  .size_hi0_i  (size_hi_i[0]),
  .committed0_i(committed_i[0]),
  .vld_o       (vld_o),
  .hit_o       (hit_o),
  .port_o      (port_o)
);

// File: tb/ilv_port_sel_bench.sv
module ilv_port_sel_bench;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [63:0] addr = '0;
  logic [3:0]  cnt_enc = 4'h2;
  logic [NS-1:0][31:0] base_lo, base_hi, size_lo, size_hi;
  logic [NS-1:0][3:0]  ig, iw;
  logic [NS-1:0]       com;
  logic [NS-1:0][63:0] tgt;
  logic        vld, hit;
  logic [7:0]  port;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_hit;
  logic [7:0] exp_port;

  always #5 clk = ~clk;

  ilv_port_sel #(.NUM_SLOTS(NS), .ADDR_W(64)) u_ilv_port_sel (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .cnt_enc_i(cnt_enc),
    .base_lo_i(base_lo), .base_hi_i(base_hi), .size_lo_i(size_lo), .size_hi_i(size_hi),
    .ig_i(ig), .iw_i(iw), .committed_i(com), .tgt_i(tgt),
    .vld_o(vld), .hit_o(hit), .port_o(port)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input logic [63:0] a);
    int lim;
    logic [64:0] b, e;
    logic [63:0] gran, gnum, ways, k;
    int w;
    exp_hit = 1'b0;
    exp_port = 8'h00;
    case (cnt_enc)
      4'h0: lim = 1;
      4'h1: lim = 2;
      4'h2: lim = 4;
      4'hd, 4'he, 4'hf: lim = 0;
      default: lim = NS;
    endcase
    for (int i = 0; i < lim; i++) begin
      b = {1'b0, base_hi[i], base_lo[i][31:28], 28'h0};
      e = b + {1'b0, size_hi[i], size_lo[i][31:28], 28'h0};
      if ({1'b0, a} >= b && {1'b0, a} < e) begin
        if (com[i]) begin
          gran = 64'd1 << (int'(ig[i]) + 8);
          gnum = a / gran;
          w = (iw[i] > 3) ? 3 : int'(iw[i]);
          ways = 64'd1 << w;
          k = gnum % ways;
          exp_hit = 1'b1;
          exp_port = 8'(tgt[i] >> (k * 8));
        end
        return;
      end
    end
  endtask

  task automatic run(input logic [63:0] a, input string tag);
    model(a);
    @(negedge clk);
    addr = a;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R1 vld"}, 64'(vld), 64'd1);
    chk({tag, " hit"}, 64'(hit), 64'(exp_hit));
    chk({tag, " port"}, 64'(port), 64'(exp_port));
  endtask

  task automatic cfg_default();
    cnt_enc = 4'h2;
    for (int s = 0; s < NS; s++) begin
      base_hi[s] = 32'(s + 1);
      base_lo[s] = (s == 3) ? 32'h8000_1234 : 32'h0000_0abc;  // low bits are junk
      size_hi[s] = 32'h0;
      size_lo[s] = 32'h1000_0fff;
      ig[s] = 4'(s);
      iw[s] = 4'(s);
      com[s] = 1'b1;
      for (int k = 0; k < 8; k++) tgt[s][k*8 +: 8] = 8'(16 * (s + 1) + k);
    end
  endtask

  function automatic logic [63:0] slot_base(input int s);
    return {base_hi[s], base_lo[s][31:28], 28'h0};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] b;
    logic       h_prev;
    logic [7:0] p_prev;
    cfg_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset vld", 64'(vld), 64'd0);
    chk("R10 reset hit", 64'(hit), 64'd0);
    chk("R10 reset port", 64'(port), 64'd0);

    // R3 R4 R7 R8: sweep granules in each slot
    for (int s = 0; s < NS; s++) begin
      b = slot_base(s);
      for (int k = 0; k < 10; k++)
        run(b + (64'(k) << (s + 8)) + 64'(k * 3), "R7 R8 sweep");
      run(b - 64'd1, "R4 below base");
      run(b + 64'h0fff_ffff, "R4 last byte");
      run(b + 64'h1000_0000, "R4 past end");
    end
    run(64'h0, "R9 no slot");

    // R5 R6: slot1 and slot2 share a window
    base_hi[2] = base_hi[1];
    base_lo[2] = base_lo[1];
    com[1] = 1'b0;
    b = slot_base(1);
    run(b + 64'h300, "R6 uncommitted first");
    com[1] = 1'b1;
    run(b + 64'h300, "R5 lowest wins");
    com[0] = 1'b0;
    run(slot_base(0) + 64'h10, "R6 slot0 uncommitted");
    cfg_default();

    // R2: every count encoding against every slot
    for (int e = 0; e < 16; e++) begin
      cnt_enc = 4'(e);
      for (int s = 0; s < NS; s++) run(slot_base(s) + 64'h900, "R2 count");
    end
    cfg_default();

    // R7: ways exponents above 3 clamp to 3
    for (int v = 0; v < 16; v++) begin
      iw[3] = 4'(v);
      for (int k = 0; k < 9; k++) run(slot_base(3) + (64'(k) << 11), "R7 iw clamp");
    end
    cfg_default();

    // R4: window ending exactly at 2^64
    base_hi[0] = 32'hffff_ffff;
    base_lo[0] = 32'hf000_0000;
    run(64'hffff_ffff_ffff_ffff, "R4 top of space");
    run(64'hffff_ffff_efff_ffff, "R4 below top window");
    cfg_default();

    // R1 R10: idle cycles keep result, no valid
    run(slot_base(2) + 64'h400, "R10 setup");
    h_prev = hit;
    p_prev = port;
    addr = 64'h0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1 idle vld", 64'(vld), 64'd0);
      chk("R10 hold hit", 64'(hit), 64'(h_prev));
      chk("R10 hold port", 64'(port), 64'(p_prev));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule